// File: doc/BRIEF.md
# Write-Back Data Cache with Byte Parity

This block is a 1 KB direct-mapped data cache with 16-byte lines that holds stores locally until a line has to be replaced. A lookup takes the line index from the virtual address and compares the stored tag against the translated physical tag, which arrives in the same cycle. A load or store that hits finishes in the cycle it is presented. Each access moves up to 64 bits, and stores choose which bytes to write with a byte mask.

On a miss the CPU request stays pending and the cache handles the memory side. If the victim line is dirty, the cache first writes it back in two 64-bit beats. It then refills the new line in two beats and repeats the lookup, which now hits. Every stored data byte has its own parity bit, and every tag has one parity bit over the whole tag. A parity mismatch raises a one-cycle error pulse, and the access is then handled as a miss that drops the damaged line.

Each memory beat uses a simple request/acknowledge handshake. Byte parity travels with the data in both directions. A refill stores the parity exactly as it arrives on the bus, and a write-back drives the stored parity back out.

Top module: `dcache_wb`

## Requirements
- R1: After reset every line is invalid, and `mem_req`, `par_err` and `rsp_ready` are low while no request is presented.
- R2: A load that hits raises `rsp_ready` in the same cycle it is presented and returns the addressed 64-bit beat on `rsp_rdata`. The beat is selected by `req_vidx[0]`, which is virtual address bit 3.
- R3: The line index is `req_vidx[6:1]` (virtual address bits [9:4]), and the hit test compares the stored tag with `req_ptag` (physical address bits [31:10]). Two accesses that share an index and a physical tag hit the same line.
- R4: A miss to an invalid or clean line issues exactly two read beats, to `{req_ptag, index, beat, 3'b000}` with beat 0 first and then beat 1, and no write beat.
- R5: While the cache is fetching or writing back a line, `rsp_ready` stays low and the CPU request is held. The request completes only after the second refill beat.
- R6: A store hit completes in one cycle, writes only the bytes whose `req_be` bit is 1 (bit k covers data bits [8k+7:8k]), leaves the other bytes unchanged and issues no memory beat.
- R7: A store hit marks the line dirty. A later miss to that index writes both victim beats back to `{old tag, index, beat, 3'b000}`, beat 0 first, with the latest data and with no read beat issued before them.
- R8: A store miss first refills the line, then merges the enabled bytes into it and leaves it dirty.
- R9: The parity bit for byte k is the XOR of that byte's eight bits. A refill stores `mem_rpar` as received. A store recomputes parity for the bytes it writes, and a write-back drives on `mem_wpar` parity that matches `mem_wdata`.
- R10: If a load finds a stored byte parity mismatch on a tag-matching line, or any lookup finds a tag parity mismatch, `par_err` is high for exactly that one lookup cycle. The line is then discarded without a write-back and refilled from memory.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU access request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_vidx | input | 7 | Virtual address bits [9:3]: line index and beat select |
| req_ptag | input | 22 | Translated physical address bits [31:10] |
| req_wdata | input | 64 | Store data |
| req_be | input | 8 | Store byte enables |
| rsp_ready | output | 1 | Access completes this cycle |
| rsp_rdata | output | 64 | Load data |
| par_err | output | 1 | Parity error pulse |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write-back beat, 0 = refill beat |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 64 | Write-back data |
| mem_wpar | output | 8 | Write-back byte parity |
| mem_ack | input | 1 | Memory accepts or delivers the current beat |
| mem_rdata | input | 64 | Refill data |
| mem_rpar | input | 8 | Refill byte parity |

## Verification
The assertions rely on two things about the inputs. The CPU holds its request (valid, direction, index and tag) unchanged until `rsp_ready`. Memory raises `mem_ack` only while `mem_req` is high. The bench meets both: its access task keeps every request field fixed until it sees `rsp_ready`, and its memory responder decides whether to acknowledge on the falling edge, only while a beat is requested, with random stalls in between. Bad refill parity is injected only on a clean line that is loaded at once, so a discarded line never holds the only copy of stored data.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
    localparam int unsigned DCW_ADDR_W      = 32;
    localparam int unsigned DCW_DATA_W      = 64;
    localparam int unsigned DCW_LINE_BYTES  = 16;
    localparam int unsigned DCW_CACHE_BYTES = 1024;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WBK  = 2'd1,
        ST_FILL = 2'd2
    } dcw_state_e;
endpackage

// File: rtl/dcw_par.sv
module dcw_par #(
    parameter int unsigned BYTES = 8
) (
    input  logic [BYTES*8-1:0] data,
    output logic [BYTES-1:0]   par
);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign par[b] = ^data[b*8 +: 8];
    end
endmodule

// File: rtl/dcw_store.sv
module dcw_store #(
    parameter int unsigned LINES = 64,
    parameter int unsigned BEATS = 2,
    parameter int unsigned DW    = 64,
    parameter int unsigned TW    = 22,
    localparam int unsigned IW   = $clog2(LINES),
    localparam int unsigned BW   = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int unsigned NB   = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    input  logic [BW-1:0] rd_beat,
    output logic          rd_valid,
    output logic          rd_dirty,
    output logic [TW-1:0] rd_tag,
    output logic          rd_tpar,
    output logic [DW-1:0] rd_data,
    output logic [NB-1:0] rd_par,
    input  logic          d_we,
    input  logic [IW-1:0] d_idx,
    input  logic [BW-1:0] d_beat,
    input  logic [NB-1:0] d_be,
    input  logic [DW-1:0] d_data,
    input  logic [NB-1:0] d_par,
    input  logic          m_we,
    input  logic [IW-1:0] m_idx,
    input  logic          m_dirty,
    input  logic [TW-1:0] m_tag,
    input  logic          m_tpar
);
    localparam int unsigned WORDS = LINES * BEATS;

    logic [DW-1:0] data_q [WORDS];
    logic [NB-1:0] par_q  [WORDS];
    logic [TW-1:0] tag_q  [LINES];
    logic          tpar_q [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;

    logic [IW+BW-1:0] rd_word;
    logic [IW+BW-1:0] wr_word;
    assign rd_word = {rd_idx, rd_beat};
    assign wr_word = {d_idx, d_beat};

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_tpar  = tpar_q[rd_idx];
    assign rd_data  = data_q[rd_word];
    assign rd_par   = par_q[rd_word];

    always_ff @(posedge clk) begin
        if (d_we) begin
            for (int b = 0; b < NB; b++) begin
                if (d_be[b]) begin
                    data_q[wr_word][b*8 +: 8] <= d_data[b*8 +: 8];
                    par_q[wr_word][b]         <= d_par[b];
                end
            end
        end
        if (m_we) begin
            tag_q[m_idx]  <= m_tag;
            tpar_q[m_idx] <= m_tpar;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (m_we) begin
            valid_q[m_idx] <= 1'b1;
            dirty_q[m_idx] <= m_dirty;
        end
    end
endmodule

// File: rtl/dcache_wb.sv
module dcache_wb
    import dcw_pkg::*;
#(
    parameter int unsigned ADDR_W      = DCW_ADDR_W,
    parameter int unsigned DATA_W      = DCW_DATA_W,
    parameter int unsigned LINE_BYTES  = DCW_LINE_BYTES,
    parameter int unsigned CACHE_BYTES = DCW_CACHE_BYTES,
    localparam int unsigned BE_W   = DATA_W / 8,
    localparam int unsigned BOFF   = $clog2(BE_W),
    localparam int unsigned OFF_W  = $clog2(LINE_BYTES),
    localparam int unsigned BEATS  = LINE_BYTES / BE_W,
    localparam int unsigned BW     = OFF_W - BOFF,
    localparam int unsigned LINES  = CACHE_BYTES / LINE_BYTES,
    localparam int unsigned IDX_W  = $clog2(LINES),
    localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_we,
    input  logic [IDX_W+BW-1:0]   req_vidx,
    input  logic [TAG_W-1:0]      req_ptag,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [BE_W-1:0]       req_be,
    output logic                  rsp_ready,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  par_err,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    output logic [BE_W-1:0]       mem_wpar,
    input  logic                  mem_ack,
    input  logic [DATA_W-1:0]     mem_rdata,
    input  logic [BE_W-1:0]       mem_rpar
);
    typedef struct packed {
        dcw_state_e       st;
        logic [BW-1:0]    beat;
        logic [IDX_W-1:0] idx;
        logic [TAG_W-1:0] tag;
        logic [TAG_W-1:0] vtag;
    } ctl_t;

    localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

    ctl_t q, d;

    logic [IDX_W-1:0] in_idx;
    logic [BW-1:0]    in_beat;
    logic [IDX_W-1:0] rd_idx;
    logic [BW-1:0]    rd_beat;
    logic             rd_valid, rd_dirty, rd_tpar;
    logic [TAG_W-1:0] rd_tag;
    logic [DATA_W-1:0] rd_data;
    logic [BE_W-1:0]  rd_par, chk_par, st_par;
    logic             idle, lookup, tag_perr, data_bad, match, data_perr, hit;
    logic             d_we, m_we, m_dirty;
    logic [BE_W-1:0]  d_be, d_par;
    logic [DATA_W-1:0] d_data;
    logic [TAG_W-1:0] m_tag;

    assign in_idx  = req_vidx[BW +: IDX_W];
    assign in_beat = req_vidx[BW-1:0];
    assign idle    = (q.st == ST_IDLE);
    assign rd_idx  = idle ? in_idx  : q.idx;
    assign rd_beat = idle ? in_beat : q.beat;

    dcw_store #(.LINES(LINES), .BEATS(BEATS), .DW(DATA_W), .TW(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_beat(rd_beat),
        .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag), .rd_tpar(rd_tpar),
        .rd_data(rd_data), .rd_par(rd_par),
        .d_we(d_we), .d_idx(rd_idx), .d_beat(rd_beat), .d_be(d_be),
        .d_data(d_data), .d_par(d_par),
        .m_we(m_we), .m_idx(rd_idx), .m_dirty(m_dirty), .m_tag(m_tag), .m_tpar(^m_tag)
    );

    dcw_par #(.BYTES(BE_W)) u_chk_par (.data(rd_data),   .par(chk_par));
    dcw_par #(.BYTES(BE_W)) u_st_par  (.data(req_wdata), .par(st_par));

    // lookup and parity check
    assign lookup    = idle && req_valid;
    assign tag_perr  = rd_valid && ((^rd_tag) ^ rd_tpar);
    assign data_bad  = |(chk_par ^ rd_par);
    assign match     = rd_valid && !tag_perr && (rd_tag == req_ptag);
    assign data_perr = lookup && !req_we && match && data_bad;
    assign hit       = lookup && match && !(!req_we && data_bad);

    assign rsp_ready = hit;
    assign rsp_rdata = rd_data;
    assign par_err   = lookup && (tag_perr || data_perr);

    // array write ports: store hit or refill beat
    always_comb begin
        d_we    = (hit && req_we) || (q.st == ST_FILL && mem_ack);
        d_be    = hit ? req_be : '1;
        d_data  = hit ? req_wdata : mem_rdata;
        d_par   = hit ? st_par : mem_rpar;
        m_we    = (hit && req_we) || (q.st == ST_FILL && mem_ack && q.beat == LAST_BEAT);
        m_dirty = hit;
        m_tag   = hit ? req_ptag : q.tag;
    end

    // memory side
    assign mem_req   = !idle;
    assign mem_we    = (q.st == ST_WBK);
    assign mem_addr  = {(q.st == ST_WBK) ? q.vtag : q.tag, q.idx, q.beat, {BOFF{1'b0}}};
    assign mem_wdata = rd_data;
    assign mem_wpar  = rd_par;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (lookup && !hit) begin
                    d.idx  = in_idx;
                    d.tag  = req_ptag;
                    d.vtag = rd_tag;
                    d.beat = '0;
                    d.st   = (rd_valid && rd_dirty && !tag_perr && !data_perr) ? ST_WBK : ST_FILL;
                end
            end
            ST_WBK: begin
                if (mem_ack) begin
                    if (q.beat == LAST_BEAT) begin
                        d.beat = '0;
                        d.st   = ST_FILL;
                    end else begin
                        d.beat = q.beat + 1'b1;
                    end
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    if (q.beat == LAST_BEAT) begin
                        d.beat = '0;
                        d.st   = ST_IDLE;
                    end else begin
                        d.beat = q.beat + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5: no completion while a line is moving
    a_r5_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !rsp_ready);
    // R5: the CPU request is held while pending (input assumption)
    a_r5_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_ready) |=> (req_valid && $stable(req_vidx) && $stable(req_ptag) && $stable(req_we)));
    // R4: beats of one line go in ascending order with the same direction
    a_r4_beat_order: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_addr[BOFF]) |=> (mem_req && mem_addr[BOFF] && $stable(mem_we)));
    // R7: write-back is followed directly by refill from beat 0
    a_r7_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack && mem_addr[BOFF]) |=> (mem_req && !mem_we && !mem_addr[BOFF]));
    // R6: a store hit starts no memory traffic
    a_r6_store_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ready && req_we) |=> !mem_req);
    // R10: error is a single pulse and leads to a refill without write-back
    a_r10_err_refill: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |=> (mem_req && !mem_we && !par_err));
    // R1: response only with a request
    a_r1_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> req_valid);
endmodule

// File: tb/dcache_wb_tb.sv
`timescale 1ns/1ps
module dcache_wb_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [6:0]  req_vidx = '0;
    logic [21:0] req_ptag = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0]  req_be = '0;
    logic        rsp_ready, par_err, mem_req, mem_we;
    logic [63:0] rsp_rdata, mem_wdata;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wpar;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic [7:0]  mem_rpar = '0;

    always #2.5 clk = ~clk;

    dcache_wb u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_vidx(req_vidx), .req_ptag(req_ptag), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .par_err(par_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_wpar(mem_wpar), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_rpar(mem_rpar)
    );

    int checks = 0, errors = 0;
    logic [63:0] refm [logic [28:0]];
    logic [63:0] memm [logic [28:0]];
    logic [32:0] tlog [$];
    logic        inj_en = 1'b0;
    logic [28:0] inj_key = '0;
    bit          finished = 1'b0;

    function automatic logic [63:0] dflt(input logic [28:0] k);
        return {3'b0, k ^ 29'h0A5A_5A5A, 3'b0, ~k};
    endfunction
    function automatic logic [7:0] bpar(input logic [63:0] v);
        logic [7:0] p;
        for (int b = 0; b < 8; b++) p[b] = ^v[b*8 +: 8];
        return p;
    endfunction
    function automatic logic [63:0] get_ref(input logic [28:0] k);
        return refm.exists(k) ? refm[k] : dflt(k);
    endfunction
    function automatic logic [63:0] get_mem(input logic [28:0] k);
        return memm.exists(k) ? memm[k] : dflt(k);
    endfunction
    function automatic logic [63:0] merge(input logic [63:0] o, input logic [63:0] n, input logic [7:0] be);
        logic [63:0] r = o;
        for (int b = 0; b < 8; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory responder: decides on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req && ($urandom % 3 != 0)) begin
                logic [28:0] k;
                k = mem_addr[31:3];
                mem_ack = 1'b1;
                tlog.push_back({mem_we, mem_addr});
                if (mem_we) begin
                    chk(mem_wdata == get_ref(k), "R7 write-back data", mem_wdata, get_ref(k));
                    chk(mem_wpar == bpar(mem_wdata), "R9 write-back parity", {56'b0, mem_wpar}, {56'b0, bpar(mem_wdata)});
                    memm[k] = mem_wdata;
                end else begin
                    mem_rdata = get_mem(k);
                    mem_rpar  = bpar(mem_rdata);
                    if (inj_en && k == inj_key) begin
                        mem_rpar[2] = ~mem_rpar[2];
                        inj_en = 1'b0;
                    end
                end
            end else begin
                mem_ack = 1'b0;
            end
        end
    end

    task automatic access(input logic we, input logic [5:0] idx, input logic beat,
                          input logic [21:0] ptag, input logic [63:0] wd, input logic [7:0] be,
                          output logic [63:0] rd, output int cyc, output int nerr, output int ls);
        logic [28:0] k;
        k = {ptag, idx, beat};
        ls = tlog.size();
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_vidx = {idx, beat}; req_ptag = ptag;
        req_wdata = wd; req_be = be;
        cyc = 0; nerr = 0; rd = '0;
        forever begin
            #1;
            cyc++;
            if (par_err) nerr++;
            if (rsp_ready) begin
                rd = rsp_rdata;
                break;
            end
            if (cyc > 2000) begin
                chk(1'b0, "R5 access hung", 64'(cyc), 64'd0);
                break;
            end
            @(negedge clk);
        end
        @(posedge clk);
        #1 req_valid = 1'b0;
        if (we) refm[k] = merge(get_ref(k), wd, be);
    endtask

    function automatic int n_new(input int ls, input bit w);
        int n = 0;
        for (int i = ls; i < tlog.size(); i++) if (tlog[i][32] == w) n++;
        return n;
    endfunction

    initial begin
        #(5.0 * 150000);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] rd;
        int cyc, nerr, ls;
        logic [21:0] T1, T2, T3, T4, T5;
        logic [21:0] tags [3];
        T1 = 22'h0ABCD; T2 = 22'h12345; T3 = 22'h00777; T4 = 22'h3F00F; T5 = 22'h2AAAA;
        void'($urandom(32'd4321));

        repeat (4) @(posedge clk);
        #1;
        chk(!mem_req && !par_err && !rsp_ready, "R1 reset outputs", {61'b0, mem_req, par_err, rsp_ready}, 64'd0);
        @(negedge clk); rst_n = 1'b1;

        // R4/R5: cold load miss
        access(1'b0, 6'd5, 1'b0, T1, '0, '0, rd, cyc, nerr, ls);
        chk(rd == get_ref({T1, 6'd5, 1'b0}), "R4 miss data", rd, get_ref({T1, 6'd5, 1'b0}));
        chk(n_new(ls, 1'b0) == 2 && n_new(ls, 1'b1) == 0, "R4 two reads no writes",
            64'(n_new(ls, 1'b0)), 64'd2);
        chk(tlog[ls][31:0] == {T1, 6'd5, 1'b0, 3'b0} && tlog[ls+1][31:0] == {T1, 6'd5, 1'b1, 3'b0},
            "R4 refill addresses", {31'b0, tlog[ls]}, {32'b0, T1, 6'd5, 1'b0, 3'b0});
        chk(cyc >= 3, "R5 stall during refill", 64'(cyc), 64'd3);

        // R2: load hit in one cycle
        access(1'b0, 6'd5, 1'b1, T1, '0, '0, rd, cyc, nerr, ls);
        chk(cyc == 1 && tlog.size() == ls, "R2 hit single cycle", 64'(cyc), 64'd1);
        chk(rd == get_ref({T1, 6'd5, 1'b1}), "R2 hit data", rd, get_ref({T1, 6'd5, 1'b1}));

        // R3: same index and physical tag hit the same line
        access(1'b0, 6'd5, 1'b0, T1, '0, '0, rd, cyc, nerr, ls);
        chk(cyc == 1 && rd == get_ref({T1, 6'd5, 1'b0}), "R3 shared line hit", rd, get_ref({T1, 6'd5, 1'b0}));

        // R6: store hit, partial bytes
        access(1'b1, 6'd5, 1'b1, T1, 64'hDEAD_BEEF_CAFE_F00D, 8'h0F, rd, cyc, nerr, ls);
        chk(cyc == 1 && tlog.size() == ls, "R6 store hit one cycle no memory", 64'(cyc), 64'd1);
        access(1'b0, 6'd5, 1'b1, T1, '0, '0, rd, cyc, nerr, ls);
        chk(rd == get_ref({T1, 6'd5, 1'b1}), "R6 merged bytes", rd, get_ref({T1, 6'd5, 1'b1}));

        // R7: dirty victim written back before refill
        access(1'b0, 6'd5, 1'b0, T2, '0, '0, rd, cyc, nerr, ls);
        chk(tlog.size() - ls == 4 && tlog[ls][32] && tlog[ls+1][32] && !tlog[ls+2][32],
            "R7 write-back then refill", 64'(tlog.size() - ls), 64'd4);
        chk(tlog[ls][31:0] == {T1, 6'd5, 1'b0, 3'b0} && tlog[ls+1][31:0] == {T1, 6'd5, 1'b1, 3'b0},
            "R7 victim addresses", {31'b0, tlog[ls]}, {32'b0, T1, 6'd5, 1'b0, 3'b0});
        chk(memm[{T1, 6'd5, 1'b1}] == refm[{T1, 6'd5, 1'b1}], "R7 memory holds store",
            memm[{T1, 6'd5, 1'b1}], refm[{T1, 6'd5, 1'b1}]);
        chk(rd == get_ref({T2, 6'd5, 1'b0}), "R7 new line data", rd, get_ref({T2, 6'd5, 1'b0}));

        // R8: store miss allocates, merges, dirty
        access(1'b1, 6'd9, 1'b0, T3, 64'h1122_3344_5566_7788, 8'hF0, rd, cyc, nerr, ls);
        chk(n_new(ls, 1'b0) == 2 && n_new(ls, 1'b1) == 0, "R8 store miss refills", 64'(n_new(ls, 1'b0)), 64'd2);
        access(1'b0, 6'd9, 1'b0, T3, '0, '0, rd, cyc, nerr, ls);
        chk(cyc == 1 && rd == get_ref({T3, 6'd9, 1'b0}), "R8 merged after refill", rd, get_ref({T3, 6'd9, 1'b0}));
        access(1'b0, 6'd9, 1'b0, T4, '0, '0, rd, cyc, nerr, ls);
        chk(n_new(ls, 1'b1) == 2, "R8 line left dirty", 64'(n_new(ls, 1'b1)), 64'd2);

        // R10: bad parity from refill is caught on load
        inj_key = {T5, 6'd12, 1'b0};
        inj_en = 1'b1;
        access(1'b0, 6'd12, 1'b0, T5, '0, '0, rd, cyc, nerr, ls);
        chk(nerr == 1, "R10 one error pulse", 64'(nerr), 64'd1);
        chk(n_new(ls, 1'b0) == 4 && n_new(ls, 1'b1) == 0, "R10 refetch without write-back",
            64'(n_new(ls, 1'b0)), 64'd4);
        chk(rd == get_ref({T5, 6'd12, 1'b0}), "R10 corrected data", rd, get_ref({T5, 6'd12, 1'b0}));

        // R9 and mixed traffic: random loads and stores over few indexes and tags
        tags[0] = T1; tags[1] = T2; tags[2] = T3;
        for (int n = 0; n < 600; n++) begin
            logic        w, bt;
            logic [5:0]  ix;
            logic [21:0] tg;
            logic [63:0] wd;
            logic [7:0]  be;
            bit          order_ok;
            bit          seen_rd;
            w  = 1'($urandom % 2);
            bt = 1'($urandom % 2);
            ix = 6'($urandom % 6);
            tg = tags[$urandom % 3];
            wd = {$urandom, $urandom};
            be = 8'($urandom);
            if (be == 0) be = 8'h01;
            access(w, ix, bt, tg, wd, be, rd, cyc, nerr, ls);
            if (!w) chk(rd == get_ref({tg, ix, bt}), "R2 random load data", rd, get_ref({tg, ix, bt}));
            order_ok = 1'b1; seen_rd = 1'b0;
            for (int i = ls; i < tlog.size(); i++) begin
                if (!tlog[i][32]) seen_rd = 1'b1;
                else if (seen_rd) order_ok = 1'b0;
            end
            if (tlog.size() != ls) chk(order_ok, "R7 no write after read", 64'(tlog.size() - ls), 64'd0);
            chk(nerr == 0, "R10 no spurious error", 64'(nerr), 64'd0);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule